// File: doc/BRIEF.md
# Software-Refilled Address Translation Buffer

This block translates 32-bit virtual addresses into 30-bit physical addresses with 4 KiB pages. It keeps a small set of translations and searches all of them at once. A virtual address splits into a 20-bit page number in bits 31..12 and a 12-bit offset in bits 11..0. A physical address is the 18-bit physical page number in bits 29..12 with the same offset below it. The result is combinational. A hit, a miss or a store-protection fault is visible in the same cycle as the access, so a pipeline can start exception handling on the next cycle.

The buffer never fetches translations itself. Software refills it through a small register file. A page-number register and an entry-data register stage one translation. An index register selects a slot. A free-running counter supplies a pseudo-random slot. A fault-address register records the virtual address that caused the last miss or protection fault. Three commands act on the staged translation: write it to the indexed slot, write it to the random slot, or read the indexed slot back into the two staging registers.

Top module: `tlbx_xlate`

## Requirements
- R1: A synchronous active-high reset invalidates every entry and clears the staging, index and fault-address registers. It loads the random counter with ENTRIES-1. After reset, every access misses.
- R2: An access whose page number matches a valid entry, and that is either a load or a store to an entry with its dirty bit set, raises `acc_hit` in the same cycle. `acc_paddr` then equals that entry's physical page number concatenated with `acc_vaddr[11:0]`.
- R3: An access that matches no valid entry raises `acc_miss` in the same cycle. With no access, or with no completed hit, `acc_hit`, `acc_miss` and `acc_mod_fault` follow the access outcome only and `acc_paddr` is zero.
- R4: On the clock edge that ends a missing or faulting access, `sw_badva` captures `acc_vaddr`. At all other times it keeps its value.
- R5: `cmd`=1 (indexed write) copies the staged page number and entry data into the slot given by `sw_idx`.
- R6: `sw_rnd` decrements by one on every clock and wraps from 0 to ENTRIES-1. `cmd`=2 (random write) copies the staged translation into the slot equal to `sw_rnd` in that cycle.
- R7: `cmd`=3 (indexed read) loads `sw_hi` and `sw_lo` from the slot given by `sw_idx` on the next edge. It takes precedence over a register write to those registers in the same cycle.
- R8: A completed hit sets the matched entry's reference bit. A fault or a miss does not set it.
- R9: A store that matches an entry whose dirty bit is clear raises `acc_mod_fault` instead of `acc_hit`, with `acc_paddr` zero.
- R10: When several valid entries match, the lowest-numbered one supplies the translation and receives the reference bit.
- R11: The entry-data layout is `{ppn[17:0], valid, dirty, ref}`, with valid at bit 2, dirty at bit 1 and ref at bit 0. An entry written with valid clear never matches.
- R12: With `reg_we` high, `reg_sel` selects the target: 0 loads `sw_hi` from `reg_wdata[19:0]`, 1 loads `sw_lo` from `reg_wdata[20:0]`, and 2 loads `sw_idx` from `reg_wdata[3:0]`. `reg_sel`=3 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | Access request this cycle |
| acc_write | input | 1 | Access is a store |
| acc_vaddr | input | 32 | Virtual address of the access |
| acc_hit | output | 1 | Translation completed |
| acc_miss | output | 1 | No valid entry matched |
| acc_mod_fault | output | 1 | Store to an entry with dirty clear |
| acc_paddr | output | 30 | Physical address on a completed hit, else zero |
| reg_we | input | 1 | Software register write strobe |
| reg_sel | input | 2 | Register select: 0 page number, 1 entry data, 2 index |
| reg_wdata | input | 21 | Software register write data |
| cmd | input | 2 | 0 none, 1 indexed write, 2 random write, 3 indexed read |
| sw_hi | output | 20 | Staged virtual page number |
| sw_lo | output | 21 | Staged entry data {ppn, valid, dirty, ref} |
| sw_idx | output | 4 | Index register |
| sw_rnd | output | 4 | Pseudo-random slot counter |
| sw_badva | output | 32 | Last faulting virtual address |

## Verification
The bench builds the block with its default sizes: 16 entries, 32-bit virtual and 30-bit physical addresses. With 16 entries the random counter wraps every 16 cycles, so random writes reach every slot, including the 0 to 15 wrap, within a short run. In the random phase, page numbers are drawn from a set of only eight values. This makes duplicate matches, priority resolution, dirty-bit faults and reference-bit updates common, not rare.

// File: rtl/tlbx_pkg.sv
package tlbx_pkg;
  typedef enum logic [1:0] {
    CMD_NONE   = 2'd0,
    CMD_WR_IDX = 2'd1,
    CMD_WR_RND = 2'd2,
    CMD_RD_IDX = 2'd3
  } tlbx_cmd_e;

  typedef enum logic [1:0] {
    SEL_HI  = 2'd0,
    SEL_LO  = 2'd1,
    SEL_IDX = 2'd2,
    SEL_NOP = 2'd3
  } tlbx_sel_e;

  // entry-data field positions (relative to bit 0)
  localparam int LO_REF_BIT = 0;
  localparam int LO_DRT_BIT = 1;
  localparam int LO_VLD_BIT = 2;
  localparam int LO_PPN_LSB = 3;
endpackage

// File: rtl/tlbx_rand.sv
module tlbx_rand #(
  parameter int ENTRIES = 16,
  localparam int IW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic          clk,
  input  logic          rst,
  output logic [IW-1:0] rnd
);
  localparam logic [IW-1:0] TOP = IW'(ENTRIES - 1);

  always_ff @(posedge clk) begin
    if (rst)             rnd <= TOP;
    else if (rnd == '0)  rnd <= TOP;
    else                 rnd <= rnd - 1'b1;
  end

  p_rnd_wrap_r6: assert property (@(posedge clk) disable iff (rst)
    (rnd == '0) |=> (rnd == TOP));
  p_rnd_step_r6: assert property (@(posedge clk) disable iff (rst)
    (rnd != '0) |=> (rnd == $past(rnd) - 1'b1));
endmodule

// File: rtl/tlbx_match.sv
module tlbx_match #(
  parameter int ENTRIES = 16,
  parameter int TAG_W   = 20,
  localparam int IW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic [ENTRIES-1:0]            vld,
  input  logic [ENTRIES-1:0][TAG_W-1:0] tags,
  input  logic [TAG_W-1:0]              key,
  output logic                          hit,
  output logic [IW-1:0]                 hit_idx
);
  logic [ENTRIES-1:0] eq;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign eq[g] = vld[g] && (tags[g] == key);
  end

  assign hit = |eq;

  // lowest-numbered matching slot wins
  always_comb begin
    hit_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (eq[i]) hit_idx = IW'(i);
    end
  end
endmodule

// File: rtl/tlbx_xlate.sv
module tlbx_xlate
  import tlbx_pkg::*;
#(
  parameter int VA_W    = 32,
  parameter int PA_W    = 30,
  parameter int OFS_W   = 12,
  parameter int ENTRIES = 16,
  localparam int VPN_W  = VA_W - OFS_W,
  localparam int PPN_W  = PA_W - OFS_W,
  localparam int LO_W   = PPN_W + 3,
  localparam int IW     = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             acc_valid,
  input  logic             acc_write,
  input  logic [VA_W-1:0]  acc_vaddr,
  output logic             acc_hit,
  output logic             acc_miss,
  output logic             acc_mod_fault,
  output logic [PA_W-1:0]  acc_paddr,
  input  logic             reg_we,
  input  logic [1:0]       reg_sel,
  input  logic [LO_W-1:0]  reg_wdata,
  input  logic [1:0]       cmd,
  output logic [VPN_W-1:0] sw_hi,
  output logic [LO_W-1:0]  sw_lo,
  output logic [IW-1:0]    sw_idx,
  output logic [IW-1:0]    sw_rnd,
  output logic [VA_W-1:0]  sw_badva
);
  logic [ENTRIES-1:0]            ent_vld, ent_drt, ent_ref;
  logic [ENTRIES-1:0][VPN_W-1:0] ent_vpn;
  logic [ENTRIES-1:0][PPN_W-1:0] ent_ppn;

  logic             m_hit;
  logic [IW-1:0]    m_idx;
  logic [VPN_W-1:0] acc_vpn;
  logic [OFS_W-1:0] acc_ofs;
  logic [IW-1:0]    wr_slot;
  logic             wr_en;

  assign acc_vpn = acc_vaddr[VA_W-1:OFS_W];
  assign acc_ofs = acc_vaddr[OFS_W-1:0];

  tlbx_rand #(.ENTRIES(ENTRIES)) u_rand (
    .clk (clk),
    .rst (rst),
    .rnd (sw_rnd)
  );

  tlbx_match #(.ENTRIES(ENTRIES), .TAG_W(VPN_W)) u_match (
    .vld     (ent_vld),
    .tags    (ent_vpn),
    .key     (acc_vpn),
    .hit     (m_hit),
    .hit_idx (m_idx)
  );

  // same-cycle outcome of the access
  always_comb begin
    acc_miss      = acc_valid && !m_hit;
    acc_mod_fault = acc_valid && m_hit && acc_write && !ent_drt[m_idx];
    acc_hit       = acc_valid && m_hit && !(acc_write && !ent_drt[m_idx]);
    acc_paddr     = acc_hit ? {ent_ppn[m_idx], acc_ofs} : '0;
  end

  assign wr_en   = (cmd == CMD_WR_IDX) || (cmd == CMD_WR_RND);
  assign wr_slot = (cmd == CMD_WR_RND) ? sw_rnd : sw_idx;

  always_ff @(posedge clk) begin
    if (rst) begin
      ent_vld  <= '0;
      ent_drt  <= '0;
      ent_ref  <= '0;
      ent_vpn  <= '0;
      ent_ppn  <= '0;
      sw_hi    <= '0;
      sw_lo    <= '0;
      sw_idx   <= '0;
      sw_badva <= '0;
    end else begin
      if (acc_miss || acc_mod_fault) sw_badva <= acc_vaddr;
      if (acc_hit) ent_ref[m_idx] <= 1'b1;

      if (reg_we) begin
        case (reg_sel)
          SEL_HI:  sw_hi  <= reg_wdata[VPN_W-1:0];
          SEL_LO:  sw_lo  <= reg_wdata;
          SEL_IDX: sw_idx <= reg_wdata[IW-1:0];
          default: ;
        endcase
      end

      // a software write to the slot overrides a same-edge reference update
      if (wr_en) begin
        ent_vpn[wr_slot] <= sw_hi;
        ent_ppn[wr_slot] <= sw_lo[LO_W-1:LO_PPN_LSB];
        ent_vld[wr_slot] <= sw_lo[LO_VLD_BIT];
        ent_drt[wr_slot] <= sw_lo[LO_DRT_BIT];
        ent_ref[wr_slot] <= sw_lo[LO_REF_BIT];
      end

      if (cmd == CMD_RD_IDX) begin
        sw_hi <= ent_vpn[sw_idx];
        sw_lo <= {ent_ppn[sw_idx], ent_vld[sw_idx], ent_drt[sw_idx], ent_ref[sw_idx]};
      end
    end
  end

  p_quiet_r3: assert property (@(posedge clk) disable iff (rst)
    !acc_valid |-> (!acc_hit && !acc_miss && !acc_mod_fault && acc_paddr == '0));
  p_one_outcome_r3: assert property (@(posedge clk) disable iff (rst)
    acc_valid |-> $onehot({acc_hit, acc_miss, acc_mod_fault}));
  p_badva_cap_r4: assert property (@(posedge clk) disable iff (rst)
    (acc_miss || acc_mod_fault) |=> (sw_badva == $past(acc_vaddr)));
  p_badva_hold_r4: assert property (@(posedge clk) disable iff (rst)
    !(acc_miss || acc_mod_fault) |=> $stable(sw_badva));
  p_fault_store_r9: assert property (@(posedge clk) disable iff (rst)
    acc_mod_fault |-> (acc_write && acc_paddr == '0));
  p_idx_hold_r12: assert property (@(posedge clk) disable iff (rst)
    !(reg_we && reg_sel == SEL_IDX) |=> $stable(sw_idx));
  p_ofs_pass_r2: assert property (@(posedge clk) disable iff (rst)
    acc_hit |-> (acc_paddr[OFS_W-1:0] == acc_vaddr[OFS_W-1:0]));
endmodule

// File: tb/tlbx_xlate_bench.sv
`timescale 1ns/1ps
module tlbx_xlate_bench;
  localparam int N = 16;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        acc_valid = 0, acc_write = 0;
  logic [31:0] acc_vaddr = '0;
  logic        acc_hit, acc_miss, acc_mod_fault;
  logic [29:0] acc_paddr;
  logic        reg_we = 0;
  logic [1:0]  reg_sel = '0;
  logic [20:0] reg_wdata = '0;
  logic [1:0]  cmd = '0;
  logic [19:0] sw_hi;
  logic [20:0] sw_lo;
  logic [3:0]  sw_idx, sw_rnd;
  logic [31:0] sw_badva;

  always #2.5 clk = ~clk;

  tlbx_xlate u_tlbx_xlate (
    .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_vaddr(acc_vaddr), .acc_hit(acc_hit), .acc_miss(acc_miss),
    .acc_mod_fault(acc_mod_fault), .acc_paddr(acc_paddr), .reg_we(reg_we),
    .reg_sel(reg_sel), .reg_wdata(reg_wdata), .cmd(cmd), .sw_hi(sw_hi),
    .sw_lo(sw_lo), .sw_idx(sw_idx), .sw_rnd(sw_rnd), .sw_badva(sw_badva)
  );

  // behavioural reference state
  bit          m_vld[N], m_drt[N], m_ref[N];
  logic [19:0] m_vpn[N];
  logic [17:0] m_ppn[N];
  logic [19:0] m_hi;
  logic [20:0] m_lo;
  int          m_idx, m_rnd;
  logic [31:0] m_bad;

  int    n_vec = 0, n_bad = 0;
  string req = "R1";
  bit    done = 0;

  function automatic logic [20:0] mk_lo(input logic [17:0] ppn, input bit v, input bit d, input bit r);
    return {ppn, v, d, r};
  endfunction

  task automatic model_reset();
    for (int i = 0; i < N; i++) begin
      m_vld[i] = 0; m_drt[i] = 0; m_ref[i] = 0; m_vpn[i] = '0; m_ppn[i] = '0;
    end
    m_hi = '0; m_lo = '0; m_idx = 0; m_rnd = N - 1; m_bad = '0;
  endtask

  task automatic cmp(input string what, input logic [31:0] act, input logic [31:0] exp);
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // drive one cycle of inputs (called just after a falling edge)
  task automatic step(input bit av, input bit aw, input logic [31:0] va,
                      input logic [1:0] c, input bit we, input logic [1:0] sel,
                      input logic [20:0] wd);
    int f; bit hit, miss, flt;
    logic [29:0] pa;
    logic [19:0] o_vpn; logic [20:0] o_lo; int o_idx, o_rnd;
    acc_valid = av; acc_write = aw; acc_vaddr = va;
    cmd = c; reg_we = we; reg_sel = sel; reg_wdata = wd;
    #1;
    f = -1;
    for (int i = N - 1; i >= 0; i--) if (m_vld[i] && m_vpn[i] == va[31:12]) f = i;
    miss = av && (f < 0);
    flt  = av && (f >= 0) && aw && !m_drt[f];
    hit  = av && (f >= 0) && !flt;
    pa   = hit ? {m_ppn[f], va[11:0]} : 30'h0;
    n_vec++;
    cmp("hit", 32'(acc_hit), 32'(hit));
    cmp("miss", 32'(acc_miss), 32'(miss));
    cmp("fault", 32'(acc_mod_fault), 32'(flt));
    cmp("paddr", 32'(acc_paddr), 32'(pa));
    cmp("hi", 32'(sw_hi), 32'(m_hi));
    cmp("lo", 32'(sw_lo), 32'(m_lo));
    cmp("idx", 32'(sw_idx), 32'(m_idx));
    cmp("rnd", 32'(sw_rnd), 32'(m_rnd));
    cmp("badva", sw_badva, m_bad);
    @(posedge clk);
    // model update with pre-edge values
    o_idx = m_idx; o_rnd = m_rnd;
    o_vpn = m_vpn[o_idx];
    o_lo  = mk_lo(m_ppn[o_idx], m_vld[o_idx], m_drt[o_idx], m_ref[o_idx]);
    if (miss || flt) m_bad = va;
    if (hit) m_ref[f] = 1;
    if (c == 2'd1 || c == 2'd2) begin
      int s;
      s = (c == 2'd2) ? o_rnd : o_idx;
      m_vpn[s] = m_hi; m_ppn[s] = m_lo[20:3];
      m_vld[s] = m_lo[2]; m_drt[s] = m_lo[1]; m_ref[s] = m_lo[0];
    end
    if (we) begin
      if (sel == 2'd0) m_hi = wd[19:0];
      else if (sel == 2'd1) m_lo = wd;
      else if (sel == 2'd2) m_idx = int'(wd[3:0]);
    end
    if (c == 2'd3) begin m_hi = o_vpn; m_lo = o_lo; end
    m_rnd = (o_rnd == 0) ? N - 1 : o_rnd - 1;
    @(negedge clk);
  endtask

  task automatic idle(); step(0, 0, 32'h0, 2'd0, 0, 2'd0, 21'h0); endtask
  task automatic wreg(input logic [1:0] sel, input logic [20:0] wd);
    step(0, 0, 32'h0, 2'd0, 1, sel, wd);
  endtask
  task automatic acc(input bit w, input logic [31:0] va);
    step(1, w, va, 2'd0, 0, 2'd0, 21'h0);
  endtask
  task automatic put(input int slot, input logic [19:0] vpn, input logic [20:0] lo);
    wreg(2'd0, 21'(vpn)); wreg(2'd1, lo); wreg(2'd2, 21'(slot));
    step(0, 0, 32'h0, 2'd1, 0, 2'd0, 21'h0);
  endtask

  initial begin
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    req = "R1"; idle(); acc(0, 32'h0000_0123);
    req = "R3"; acc(0, 32'hABCD_E456); idle(); acc(1, 32'h1234_5FFF);
    req = "R4"; idle(); idle();
    req = "R5"; put(3, 20'h0ABCD, mk_lo(18'h2_1234, 1, 1, 0));
    req = "R2"; acc(0, 32'h0ABC_D7E1); acc(1, 32'h0ABC_D000);
    req = "R8"; wreg(2'd2, 21'd3); step(0, 0, 0, 2'd3, 0, 2'd0, 0); idle();
    req = "R9"; put(5, 20'h00042, mk_lo(18'h0_0777, 1, 0, 0));
    acc(1, 32'h0004_2ABC); acc(0, 32'h0004_2ABC);
    req = "R8"; wreg(2'd2, 21'd5); step(0, 0, 0, 2'd3, 0, 2'd0, 0);
    req = "R10"; put(9, 20'h00042, mk_lo(18'h1_1111, 1, 1, 0));
    put(1, 20'h00042, mk_lo(18'h3_3333, 1, 1, 0));
    acc(0, 32'h0004_2010); acc(1, 32'h0004_2020);
    req = "R11"; put(7, 20'h00777, mk_lo(18'h0_0999, 0, 1, 0)); acc(0, 32'h0077_7000);
    req = "R6"; wreg(2'd0, 21'h00555); wreg(2'd1, mk_lo(18'h0_0555, 1, 1, 0));
    for (int k = 0; k < 20; k++) step(0, 0, 0, 2'd2, 0, 2'd0, 0);
    acc(0, 32'h0055_5444);
    req = "R12"; wreg(2'd3, 21'h1F_FFFF); idle();
    req = "R7"; wreg(2'd2, 21'd1);
    step(0, 0, 0, 2'd3, 1, 2'd0, 21'h0_0F0F); idle();
    req = "R1"; rst = 1; @(posedge clk); model_reset(); @(negedge clk); rst = 0;
    idle(); acc(0, 32'h0004_2010);
    req = "R2/R3/R10 mixed";
    for (int k = 0; k < 600; k++) begin
      logic [31:0] va; logic [20:0] wd; logic [1:0] sl;
      va = {17'h0, 3'($urandom), 12'($urandom)};
      sl = 2'($urandom);
      wd = (sl == 2'd0) ? 21'(3'($urandom)) : 21'($urandom);
      if (sl == 2'd1 && ($urandom % 4 != 0)) wd[2] = 1'b1;
      step($urandom % 3 != 0, $urandom % 2 == 0, va, 2'($urandom),
           $urandom % 2 == 0, sl, wd);
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #50000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule